// File: doc/BRIEF.md
# Transmit Packet Admission Buffer

This block sits between a user packet stream and the encryption and framing stage that follows it. The user stream is 64 bits wide and byte-enabled, with valid, ready, last and error signals. The block writes each incoming packet into a circular word store and counts its bytes as they arrive. It decides at the last beat whether the packet is kept. A packet is kept only if every beat carried a legal byte enable, the user did not cancel it, and its length does not exceed 8928 bytes. A kept packet is committed in one step. A rejected packet is dropped whole by moving the write pointer back to where the packet began.

Committed packets are drained in arrival order. A small side queue holds the byte length of each committed packet. The output stage reads that queue to produce a first-beat marker, a final-beat marker, a byte enable for the final beat, and the byte count, which stays valid for the whole packet. The downstream stage can stall the output at any cycle. One parameter sets the store to 16 kB or 64 kB. The block has a single clock.

Top module: `txadm_buffer`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `outValid` is 0. `inReady` is 0 during reset and 1 once reset is released with an empty store.
- R2: A committed packet leaves with its words in order and its data unchanged. `outStart` is high on the first beat and `outLast` on the final beat. `outLen` gives the packet's byte count on every beat. `outByteEn` is 0xFF on every beat except the final one, where it is (1<<(len mod 8))-1, or 0xFF when len mod 8 is 0. Bit n of a byte enable qualifies byte n, and byte 0 is bits [7:0].
- R3: A packet whose final beat has `inErr`=1 produces no output beat. The next packet is delivered intact.
- R4: A packet of exactly 8928 bytes is committed. A packet longer than 8928 bytes is discarded whole.
- R5: A packet is discarded whole if a non-final beat has an enable other than 0xFF. It is also discarded if its final beat has an enable that is not one of 0x01, 0x03, 0x07, 0x0F, 0x1F, 0x3F, 0x7F or 0xFF.
- R6: `inReady` can drop only between packets. It is 0 there when the free space is smaller than 1116 words (one 8928-byte packet) and 1 when at least that much is free. The store holds 2048 words when `BUF_SEL`=0 and 8192 words when it is 1. Once a packet's first beat has been accepted, `inReady` stays 1 until its final beat.
- R7: While `outValid`=1 and `outReady`=0, every output stays unchanged.
- R8: Idle cycles in which `inValid`=0 may appear between beats of a packet without changing the packet that is delivered.
- R9: Each committed packet leaves as exactly one output packet, in commit order. Packets are never merged or split, and discarded packets produce no beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Reset, active low |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Block accepts the input beat |
| inData | input | 64 | Input beat data |
| inByteEn | input | 8 | Input byte enable, bit n for byte n |
| inLast | input | 1 | Final beat of the input packet |
| inErr | input | 1 | Cancel the packet, sampled with `inLast` |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream accepts the output beat |
| outData | output | 64 | Output beat data |
| outByteEn | output | 8 | Output byte enable |
| outStart | output | 1 | First beat of an output packet |
| outLast | output | 1 | Final beat of an output packet |
| outLen | output | 14 | Byte count of the current output packet |

## Verification
The bench aims at the exact length limit: 8928 bytes must pass and 8929 bytes must vanish. A design with an off-by-one compare would either drop the largest legal packet or forward one byte too many. It cancels a packet and sends a clean packet straight after it. A design that did not roll back the write pointer would emit stale words ahead of the clean packet. It probes the free-space threshold at exactly 932 and 933 stored words, and confirms that a large packet arriving just above the threshold never sees `inReady` drop part-way. A design that throttled mid-packet or checked free space against the wrong capacity would fail both probes. Illegal byte enables, input pauses and output stalls check that a malformed packet is dropped, that idle cycles do not corrupt a packet, and that a stalled output holds still.

// File: rtl/txadm_pkg.sv
package txadm_pkg;
  localparam int BEAT_BYTES = 8;
  localparam int MAX_BYTES  = 8928;
  localparam int MAX_WORDS  = (MAX_BYTES + BEAT_BYTES - 1) / BEAT_BYTES;
  localparam int LEN_W      = $clog2(MAX_BYTES + 1);
  localparam int CNT_W      = LEN_W + 1;

  // strobes from admission control to the datapath
  typedef struct packed {
    logic             wr;
    logic             commit;
    logic             discard;
    logic [LEN_W-1:0] len;
  } admit_ctl_t;

  function automatic int depthWords(input int sel);
    return (sel != 0) ? (65536 / BEAT_BYTES) : (16384 / BEAT_BYTES);
  endfunction
endpackage

// File: rtl/txadm_ctrl.sv
module txadm_ctrl
  import txadm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       inErr,
  input  logic [7:0] inByteEn,
  input  logic       spaceOk,
  output logic       inReady,
  output admit_ctl_t ctl
);
  logic             inPkt;
  logic             fmtBad;
  logic [CNT_W-1:0] byteCnt;

  logic             beat;
  logic             lastLegal;
  logic             fmtNow;
  logic             overNow;
  logic [3:0]       nBytes;
  logic [8:0]       enPlus;
  logic [CNT_W-1:0] newCnt;

  always_comb begin
    // space is only judged at a packet boundary; once begun, a packet is never throttled
    inReady   = rstN & (inPkt | spaceOk);
    beat      = inValid & inReady;
    enPlus    = {1'b0, inByteEn} + 9'd1;
    lastLegal = (inByteEn != 8'h00) && ((enPlus[7:0] & inByteEn) == 8'h00);
    nBytes    = inLast ? 4'($countones(inByteEn)) : 4'd8;
    fmtNow    = inLast ? !lastLegal : (inByteEn != 8'hFF);
    newCnt    = byteCnt + CNT_W'(nBytes);
    overNow   = newCnt > CNT_W'(MAX_BYTES);

    ctl.wr      = beat & !overNow;
    ctl.commit  = beat & inLast & !inErr & !fmtBad & !fmtNow & !overNow;
    ctl.discard = beat & inLast & !ctl.commit;
    ctl.len     = newCnt[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPkt   <= 1'b0;
      fmtBad  <= 1'b0;
      byteCnt <= '0;
    end else if (beat) begin
      if (inLast) begin
        inPkt   <= 1'b0;
        fmtBad  <= 1'b0;
        byteCnt <= '0;
      end else begin
        inPkt   <= 1'b1;
        fmtBad  <= fmtBad | fmtNow;
        byteCnt <= overNow ? CNT_W'(MAX_BYTES + 1) : newCnt;
      end
    end
  end

  // R6: after a non-final beat is taken, the rest of the packet is never stalled
  p_midpkt_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    (beat && !inLast) |=> inReady);

  // R4: a committed length is never empty and never above the limit
  p_commit_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |-> (ctl.len != '0 && ctl.len <= LEN_W'(MAX_BYTES)));
endmodule

// File: rtl/txadm_dpath.sv
module txadm_dpath
  import txadm_pkg::*;
#(
  parameter int BUF_SEL   = 0,
  parameter int LEN_DEPTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  admit_ctl_t       ctl,
  input  logic [63:0]      inData,
  output logic             spaceOk,
  input  logic             outReady,
  output logic             outValid,
  output logic [63:0]      outData,
  output logic [7:0]       outByteEn,
  output logic             outStart,
  output logic             outLast,
  output logic [LEN_W-1:0] outLen
);
  localparam int DEPTH = depthWords(BUF_SEL);
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = AW + 1;
  localparam int LAW   = $clog2(LEN_DEPTH);
  localparam int LPW   = LAW + 1;

  logic [63:0]      mem    [DEPTH];
  logic [LEN_W-1:0] lenMem [LEN_DEPTH];

  logic [PW-1:0]    wrPtr, cmPtr, rdPtr, used;
  logic [LPW-1:0]   lWr, lRd;
  logic             lenFull, lenEmpty;
  logic [LEN_W-1:0] headLen, nWords, wIdx;
  logic [2:0]       tail;
  logic             popBeat;

  always_ff @(posedge clk) begin
    if (ctl.wr) mem[wrPtr[AW-1:0]] <= inData;
    if (ctl.commit) lenMem[lWr[LAW-1:0]] <= ctl.len;
  end

  always_comb begin
    used     = wrPtr - rdPtr;
    lenEmpty = (lWr == lRd);
    lenFull  = ((lWr - lRd) == LPW'(LEN_DEPTH));
    spaceOk  = ((PW'(DEPTH) - used) >= PW'(MAX_WORDS)) && !lenFull;

    headLen   = lenMem[lRd[LAW-1:0]];
    nWords    = (headLen + LEN_W'(7)) >> 3;
    tail      = headLen[2:0];
    outValid  = !lenEmpty;
    outData   = mem[rdPtr[AW-1:0]];
    outLen    = headLen;
    outStart  = (wIdx == '0);
    outLast   = (wIdx == nWords - LEN_W'(1));
    outByteEn = (outLast && tail != 3'd0) ? (8'hFF >> (4'd8 - {1'b0, tail})) : 8'hFF;
    popBeat   = outValid & outReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      cmPtr <= '0;
      rdPtr <= '0;
      lWr   <= '0;
      lRd   <= '0;
      wIdx  <= '0;
    end else begin
      if (ctl.discard)  wrPtr <= cmPtr;
      else if (ctl.wr)  wrPtr <= wrPtr + PW'(1);
      if (ctl.commit) begin
        cmPtr <= wrPtr + PW'(ctl.wr);
        lWr   <= lWr + LPW'(1);
      end
      if (popBeat) begin
        rdPtr <= rdPtr + PW'(1);
        if (outLast) begin
          wIdx <= '0;
          lRd  <= lRd + LPW'(1);
        end else begin
          wIdx <= wIdx + LEN_W'(1);
        end
      end
    end
  end

  // R6: a write never lands on words still waiting to be read
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wr |-> (used < PW'(DEPTH)));

  // R6: committed region never exceeds the capacity
  p_commit_fits_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmPtr - rdPtr) <= PW'(DEPTH));

  // R9: the admission side never commits into a full length queue
  p_len_queue_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |-> !lenFull);

  // R7: a stalled output beat holds still
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outByteEn)
                                 && $stable(outLen) && $stable(outStart) && $stable(outLast)));
endmodule

// File: rtl/txadm_buffer.sv
module txadm_buffer
  import txadm_pkg::*;
#(
  parameter int BUF_SEL   = 0,
  parameter int LEN_DEPTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [63:0]      inData,
  input  logic [7:0]       inByteEn,
  input  logic             inLast,
  input  logic             inErr,
  output logic             outValid,
  input  logic             outReady,
  output logic [63:0]      outData,
  output logic [7:0]       outByteEn,
  output logic             outStart,
  output logic             outLast,
  output logic [LEN_W-1:0] outLen
);
  admit_ctl_t ctl;
  logic       spaceOk;

  txadm_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .inErr    (inErr),
    .inByteEn (inByteEn),
    .spaceOk  (spaceOk),
    .inReady  (inReady),
    .ctl      (ctl)
  );

  txadm_dpath #(.BUF_SEL(BUF_SEL), .LEN_DEPTH(LEN_DEPTH)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .inData    (inData),
    .spaceOk   (spaceOk),
    .outReady  (outReady),
    .outValid  (outValid),
    .outData   (outData),
    .outByteEn (outByteEn),
    .outStart  (outStart),
    .outLast   (outLast),
    .outLen    (outLen)
  );
endmodule

// File: tb/txadm_buffer_tb_top.sv
`timescale 1ns/1ps
module txadm_buffer_tb_top;
  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inLast = 1'b0, inErr = 1'b0;
  logic [63:0] inData = '0;
  logic [7:0]  inByteEn = '0;
  logic        inReady;
  logic        outValid, outStart, outLast;
  logic        outReady = 1'b1;
  logic [63:0] outData;
  logic [7:0]  outByteEn;
  logic [13:0] outLen;

  int checks = 0;
  int errors = 0;
  int expPkts = 0;
  int rxPkts = 0;
  int beatIdx = 0;
  bit done = 0;
  int expId[$];
  int expLen[$];

  always #HALF clk = ~clk;

  txadm_buffer dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inByteEn(inByteEn), .inLast(inLast), .inErr(inErr), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outByteEn(outByteEn), .outStart(outStart),
    .outLast(outLast), .outLen(outLen)
  );

  // kind: 0 good, 1 cancelled, 2 oversize, 3 bad middle enable, 4 bad final enable
  typedef struct packed {
    logic [15:0] nbytes;
    logic [2:0]  kind;
    logic        pause;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{16'd64,   3'd0, 1'b0},
    '{16'd13,   3'd0, 1'b0},
    '{16'd1,    3'd0, 1'b0},
    '{16'd20,   3'd1, 1'b0},
    '{16'd8,    3'd0, 1'b0},
    '{16'd8929, 3'd2, 1'b0},
    '{16'd8928, 3'd0, 1'b0},
    '{16'd24,   3'd3, 1'b0},
    '{16'd17,   3'd4, 1'b0},
    '{16'd100,  3'd0, 1'b1},
    '{16'd7,    3'd0, 1'b0}
  };

  function automatic logic [63:0] pat(input int id, input int w);
    logic [15:0] a, b;
    a = 16'(id);
    b = 16'(w);
    return {a, b, ~a, ~b};
  endfunction

  function automatic logic [7:0] tailEn(input int nbytes);
    int r;
    r = nbytes % 8;
    return (r == 0) ? 8'hFF : 8'((1 << r) - 1);
  endfunction

  function automatic string tagOf(input int kind, input int pause);
    if (pause != 0) return "R8";
    case (kind)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // output monitor: sampled well after the falling edge
  always @(negedge clk) begin
    #3;
    if (!done && outValid && outReady) begin
      if (expId.size() == 0) begin
        check(1'b0, "R9", "beat with no packet expected", 1, 0);
      end else begin
        int id, len, nW;
        logic [7:0] eEn;
        logic [63:0] mask, eData;
        bit ok;
        id  = expId[0];
        len = expLen[0];
        nW  = (len + 7) / 8;
        eEn = (beatIdx == nW - 1) ? tailEn(len) : 8'hFF;
        for (int b = 0; b < 8; b++) mask[b*8 +: 8] = {8{eEn[b]}};
        eData = pat(id, beatIdx);
        ok = (outStart == (beatIdx == 0)) && (outLast == (beatIdx == nW - 1)) &&
             (outLen == 14'(len)) && (outByteEn == eEn) && ((outData & mask) == (eData & mask));
        check(ok, "R2/R9", $sformatf("pkt %0d beat %0d data/en/len/marks", id, beatIdx),
              {outData[31:0], 8'(outByteEn), 4'(outStart), 4'(outLast), 16'(outLen)},
              {eData[31:0], eEn, 4'(beatIdx == 0), 4'(beatIdx == nW - 1), 16'(len)});
        if (beatIdx == nW - 1) begin
          void'(expId.pop_front());
          void'(expLen.pop_front());
          beatIdx = 0;
          rxPkts++;
        end else begin
          beatIdx++;
        end
      end
    end
  end

  task automatic send_pkt(input int id, input int nbytes, input int kind,
                          input int pause, output int stalls);
    int nW;
    nW = (nbytes + 7) / 8;
    stalls = 0;
    if (kind == 0) begin
      expId.push_back(id);
      expLen.push_back(nbytes);
      expPkts++;
    end
    for (int w = 0; w < nW; w++) begin
      inValid  = 1'b1;
      inData   = pat(id, w);
      inLast   = (w == nW - 1);
      inByteEn = (w == nW - 1) ? tailEn(nbytes) : 8'hFF;
      if (kind == 3 && w == 0) inByteEn = 8'h7F;
      if (kind == 4 && w == nW - 1) inByteEn = 8'h05;
      inErr    = (kind == 1) && (w == nW - 1);
      #1;
      while (!inReady) begin
        if (w != 0) stalls++;
        @(negedge clk);
        #1;
      end
      @(negedge clk);
      if (pause != 0 && (w % 2 == 0)) begin
        inValid = 1'b0;
        @(negedge clk);
      end
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    inErr   = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet;
    quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      #4;
      if (!outValid) quiet++;
      else quiet = 0;
    end
  endtask

  initial begin
    #(2 * HALF * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int st;
    logic [63:0] held;
    // reset behaviour
    repeat (3) @(negedge clk);
    #1;
    check(!outValid, "R1", "outValid in reset", outValid, 0);
    check(!inReady, "R1", "inReady in reset", inReady, 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(!outValid, "R1", "outValid after reset", outValid, 0);
    check(inReady, "R1", "inReady after reset", inReady, 1);

    // vector table
    for (int i = 0; i < 11; i++) begin
      send_pkt(100 + i, int'(VECS[i].nbytes), int'(VECS[i].kind), int'(VECS[i].pause), st);
      wait_idle();
      check(rxPkts == expPkts, tagOf(int'(VECS[i].kind), int'(VECS[i].pause)),
            $sformatf("packets out after vector %0d", i), rxPkts, expPkts);
    end

    // output stall holds the beat
    outReady = 1'b0;
    send_pkt(200, 16, 0, 0, st);
    repeat (2) @(negedge clk);
    #1;
    check(outValid && outStart && outLen == 14'd16, "R7", "stalled first beat present",
          {outValid, outStart, 14'(outLen)}, {1'b1, 1'b1, 14'd16});
    held = outData;
    repeat (3) @(negedge clk);
    #1;
    check(outValid && outData == held, "R7", "stalled beat unchanged", outData, held);
    outReady = 1'b1;
    wait_idle();
    check(rxPkts == expPkts, "R7", "stalled packet delivered", rxPkts, expPkts);

    // no throttling mid-packet, threshold at packet boundary
    outReady = 1'b0;
    send_pkt(300, 7200, 0, 0, st);
    #1;
    check(inReady, "R6", "ready with 900 words stored", inReady, 1);
    send_pkt(301, 8928, 0, 0, st);
    check(st == 0, "R6", "stalls inside max packet", st, 0);
    #1;
    check(!inReady, "R6", "not ready with 2016 words stored", inReady, 0);
    outReady = 1'b1;
    wait_idle();
    check(inReady, "R6", "ready after drain", inReady, 1);

    // exact boundary: 932 words leaves 1116 free, 933 does not
    outReady = 1'b0;
    send_pkt(302, 7456, 0, 0, st);
    #1;
    check(inReady, "R6", "ready with 932 words stored", inReady, 1);
    send_pkt(303, 8, 0, 0, st);
    #1;
    check(!inReady, "R6", "not ready with 933 words stored", inReady, 0);
    outReady = 1'b1;
    wait_idle();
    check(rxPkts == expPkts, "R9", "all committed packets delivered", rxPkts, expPkts);
    check(expId.size() == 0, "R9", "nothing left outstanding", expId.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule